// File: doc/BRIEF.md
# Windowed Pixel Write Sequencer

This block takes a rectangular window update and turns a stream of pixel bytes into byte writes on a frame buffer. Software first sets the window corners, the pixel format code and a source selector on plain configuration pins. A setup strobe checks these values and computes the window width, height and total byte count. If no strobe was given, the first streamed byte runs the same setup itself.

Each accepted byte is written to the frame buffer at the address of its pixel. The address moves along one window row and then jumps down one panel row. A down-counter tracks the bytes still owed. When it reaches zero the window is committed: `done` pulses for one cycle and the window is merged into a dirty bounding rectangle. A read strobe empties that rectangle.

The byte input is a valid/ready stream. `in_ready` is low only in a cycle where `setup_req` is high, and a byte counts as accepted only when `in_valid` and `in_ready` are both high. A source that sees `in_ready` low must hold its byte and its valid until a later cycle. Configuration, strobes and status are plain pins.

Top module: `win_write_seq`

## Requirements
- R1: After reset `fb_we`, `done` and `err` are 0, and the dirty rectangle is empty: both minimum outputs read 2047 and both maximum outputs read 0.
- R2: The format code on `cfg_fmt` gives the bytes per pixel: code 1 gives 2, codes 2 and 3 give 3, codes 5 and 6 give 4, and every other code gives 0.
- R3: A setup attempt is rejected when `cfg_src` is greater than 3, when the format gives 0 bytes per pixel, when `cfg_x1 < cfg_x0`, or when `cfg_y1 < cfg_y0`. A rejected attempt raises `err` for exactly one cycle, in the cycle after the attempt, and causes no frame-buffer write.
- R4: A window is (x1-x0+1) pixels wide and (y1-y0+1) rows high. It takes bytes_per_pixel × width × height accepted bytes. `done` pulses for one cycle in the cycle after the byte that completes the window, and at no other time.
- R5: If a byte is accepted while no window is open, that byte first runs setup. If setup passes, the byte is written as byte 0 of the new window. If setup fails, the byte is dropped and `err` pulses.
- R6: Let bpp be the bytes per pixel and W the window width. Byte k of a window is written at address ((y0 + r) × PANEL_W + x0) × bpp + c, where r = k / (bpp × W) and c = k mod (bpp × W).
- R7: `fb_we` is high in the cycle after each accepted byte of an open window. In that cycle `fb_data` carries the byte and `fb_addr` carries its address. In every other cycle `fb_we` is low.
- R8: While `setup_req` is high, `in_ready` is low. A `setup_req` that passes opens a new window and abandons any window that was partly written.
- R9: On commit, each dirty minimum takes the smaller of its old value and the window start. Each dirty maximum takes the larger of its old value and the exclusive window end (x1+1 or y1+1).
- R10: A `dirty_rd` pulse empties the dirty rectangle in the next cycle. If a commit happens in the same cycle as the pulse, the rectangle becomes exactly that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_req | input | 1 | Explicit setup strobe |
| cfg_src | input | 3 | Source selector, legal values 0 to 3 |
| cfg_fmt | input | 4 | Pixel format code |
| cfg_x0 | input | COORD_W | Window start column |
| cfg_y0 | input | COORD_W | Window start row |
| cfg_x1 | input | COORD_W | Window end column (inclusive) |
| cfg_y1 | input | COORD_W | Window end row (inclusive) |
| in_valid | input | 1 | Pixel byte valid |
| in_ready | output | 1 | Pixel byte can be accepted |
| in_data | input | 8 | Pixel byte |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_addr | output | ADDR_W | Frame-buffer byte address |
| fb_data | output | 8 | Frame-buffer write byte |
| done | output | 1 | Window complete pulse |
| err | output | 1 | Setup rejected pulse |
| dirty_rd | input | 1 | Read-and-clear strobe for the dirty rectangle |
| dirty_x0 | output | COORD_W+1 | Dirty minimum column |
| dirty_y0 | output | COORD_W+1 | Dirty minimum row |
| dirty_x1 | output | COORD_W+1 | Dirty maximum column (exclusive) |
| dirty_y1 | output | COORD_W+1 | Dirty maximum row (exclusive) |

## Verification
The hardest states to reach from the ports involve the window counter at a boundary while a second event lands in the same cycle. One case is a read-and-clear strobe that meets the final byte of a window. The bench raises `dirty_rd` together with that last byte and expects the rectangle to hold exactly that window.

Another case is a fresh setup that arrives while a window is only partly written. The bench streams one byte of a window and then strobes a new setup. It expects all new addresses to start from byte 0 and `done` to appear only after the full new count.

A third case is an implicit setup that fails. The bench streams a byte with an illegal format while no window is open and expects no write.

// File: rtl/wps_pkg.sv
package wps_pkg;
  // Bytes per pixel never exceed four, so three bits suffice.
  localparam int BPP_W = 3;
  typedef logic [BPP_W-1:0] bpp_t;
endpackage

// File: rtl/wps_fmt_lut.sv
module wps_fmt_lut
  import wps_pkg::*;
(
  input  logic [3:0] fmt,
  output bpp_t       bpp
);
  // Codes without a byte size report zero, which setup rejects.
  always_comb begin
    case (fmt)
      4'd1:          bpp = bpp_t'(2);
      4'd2, 4'd3:    bpp = bpp_t'(3);
      4'd5, 4'd6:    bpp = bpp_t'(4);
      default:       bpp = bpp_t'(0);
    endcase
  end
endmodule

// File: rtl/wps_win_calc.sv
module wps_win_calc
  import wps_pkg::*;
#(
  parameter int PANEL_W = 800,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 22,
  parameter int LEN_W   = 23
) (
  input  logic [2:0]          src,
  input  bpp_t                bpp,
  input  logic [COORD_W-1:0]  x0,
  input  logic [COORD_W-1:0]  y0,
  input  logic [COORD_W-1:0]  x1,
  input  logic [COORD_W-1:0]  y1,
  output logic                ok,
  output logic [LEN_W-1:0]    len,
  output logic [ADDR_W-1:0]   base,
  output logic [ADDR_W-1:0]   pitch,
  output logic [COORD_W+2:0]  row_bytes
);
  logic [COORD_W:0] w, h;

  always_comb begin
    ok        = (src <= 3'd3) && (bpp != '0) && (x1 >= x0) && (y1 >= y0);
    w         = {1'b0, x1} - {1'b0, x0} + 1'b1;
    h         = {1'b0, y1} - {1'b0, y0} + 1'b1;
    len       = LEN_W'(bpp) * LEN_W'(w) * LEN_W'(h);
    base      = (ADDR_W'(y0) * ADDR_W'(PANEL_W) + ADDR_W'(x0)) * ADDR_W'(bpp);
    pitch     = ADDR_W'(PANEL_W) * ADDR_W'(bpp);
    row_bytes = (COORD_W+3)'(bpp) * (COORD_W+3)'(w);
  end
endmodule

// File: rtl/wps_dirty_rect.sv
module wps_dirty_rect #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic               clear,
  input  logic [COORD_W:0]   wx0,
  input  logic [COORD_W:0]   wy0,
  input  logic [COORD_W:0]   wxe,
  input  logic [COORD_W:0]   wye,
  output logic [COORD_W:0]   rx0,
  output logic [COORD_W:0]   ry0,
  output logic [COORD_W:0]   rx1,
  output logic [COORD_W:0]   ry1
);
  localparam logic [COORD_W:0] EMPTY_MIN = '1;
  localparam logic [COORD_W:0] EMPTY_MAX = '0;

  logic [COORD_W:0] bx0, by0, bx1, by1;

  // On a clear the merge starts from the empty rectangle.
  always_comb begin
    bx0 = clear ? EMPTY_MIN : rx0;
    by0 = clear ? EMPTY_MIN : ry0;
    bx1 = clear ? EMPTY_MAX : rx1;
    by1 = clear ? EMPTY_MAX : ry1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx0 <= EMPTY_MIN;
      ry0 <= EMPTY_MIN;
      rx1 <= EMPTY_MAX;
      ry1 <= EMPTY_MAX;
    end else if (commit) begin
      rx0 <= (wx0 < bx0) ? wx0 : bx0;
      ry0 <= (wy0 < by0) ? wy0 : by0;
      rx1 <= (wxe > bx1) ? wxe : bx1;
      ry1 <= (wye > by1) ? wye : by1;
    end else if (clear) begin
      rx0 <= EMPTY_MIN;
      ry0 <= EMPTY_MIN;
      rx1 <= EMPTY_MAX;
      ry1 <= EMPTY_MAX;
    end
  end
endmodule

// File: rtl/win_write_seq.sv
module win_write_seq
  import wps_pkg::*;
#(
  parameter int PANEL_W = 800,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = $clog2(PANEL_W * (1 << COORD_W) * 4),
  parameter int LEN_W   = $clog2(4 * (1 << COORD_W) * (1 << COORD_W) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                setup_req,
  input  logic [2:0]          cfg_src,
  input  logic [3:0]          cfg_fmt,
  input  logic [COORD_W-1:0]  cfg_x0,
  input  logic [COORD_W-1:0]  cfg_y0,
  input  logic [COORD_W-1:0]  cfg_x1,
  input  logic [COORD_W-1:0]  cfg_y1,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  output logic                fb_we,
  output logic [ADDR_W-1:0]   fb_addr,
  output logic [7:0]          fb_data,
  output logic                done,
  output logic                err,
  input  logic                dirty_rd,
  output logic [COORD_W:0]    dirty_x0,
  output logic [COORD_W:0]    dirty_y0,
  output logic [COORD_W:0]    dirty_x1,
  output logic [COORD_W:0]    dirty_y1
);
  localparam int RB_W = COORD_W + 3;

  bpp_t              cfg_bpp;
  logic              calc_ok;
  logic [LEN_W-1:0]  calc_len;
  logic [ADDR_W-1:0] calc_base, calc_pitch;
  logic [RB_W-1:0]   calc_rb;

  wps_fmt_lut u_lut (.fmt(cfg_fmt), .bpp(cfg_bpp));

  wps_win_calc #(
    .PANEL_W(PANEL_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_calc (
    .src(cfg_src), .bpp(cfg_bpp),
    .x0(cfg_x0), .y0(cfg_y0), .x1(cfg_x1), .y1(cfg_y1),
    .ok(calc_ok), .len(calc_len), .base(calc_base),
    .pitch(calc_pitch), .row_bytes(calc_rb)
  );

  // State of the open window.
  logic [LEN_W-1:0]   rem;
  logic [ADDR_W-1:0]  cur, row_base, pitch_r;
  logic [RB_W-1:0]    col_left, rb_r;
  logic [COORD_W:0]   wx0_r, wy0_r, wxe_r, wye_r;

  logic accept, need_setup, imp_load, take, err_n, last;
  logic [LEN_W-1:0]   e_rem;
  logic [ADDR_W-1:0]  e_cur, e_row, e_pitch;
  logic [RB_W-1:0]    e_col, e_rb;
  logic [COORD_W:0]   e_x0, e_y0, e_xe, e_ye;

  assign in_ready = !setup_req;

  always_comb begin
    accept     = in_valid && in_ready;
    need_setup = accept && (rem == '0);
    imp_load   = need_setup && calc_ok;
    take       = accept && ((rem != '0) || calc_ok);
    err_n      = (setup_req || need_setup) && !calc_ok;
    // An implicit setup feeds the same cycle's byte from fresh values.
    e_rem   = imp_load ? calc_len   : rem;
    e_cur   = imp_load ? calc_base  : cur;
    e_row   = imp_load ? calc_base  : row_base;
    e_pitch = imp_load ? calc_pitch : pitch_r;
    e_col   = imp_load ? calc_rb    : col_left;
    e_rb    = imp_load ? calc_rb    : rb_r;
    e_x0    = imp_load ? {1'b0, cfg_x0} : wx0_r;
    e_y0    = imp_load ? {1'b0, cfg_y0} : wy0_r;
    e_xe    = imp_load ? ({1'b0, cfg_x1} + 1'b1) : wxe_r;
    e_ye    = imp_load ? ({1'b0, cfg_y1} + 1'b1) : wye_r;
    last    = take && (e_rem == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_we    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      fb_addr  <= '0;
      fb_data  <= '0;
      rem      <= '0;
      cur      <= '0;
      row_base <= '0;
      pitch_r  <= '0;
      col_left <= '0;
      rb_r     <= '0;
      wx0_r    <= '0;
      wy0_r    <= '0;
      wxe_r    <= '0;
      wye_r    <= '0;
    end else begin
      fb_we <= take;
      done  <= last;
      err   <= err_n;
      if (setup_req && calc_ok) begin
        rem      <= calc_len;
        cur      <= calc_base;
        row_base <= calc_base;
        pitch_r  <= calc_pitch;
        col_left <= calc_rb;
        rb_r     <= calc_rb;
        wx0_r    <= {1'b0, cfg_x0};
        wy0_r    <= {1'b0, cfg_y0};
        wxe_r    <= {1'b0, cfg_x1} + 1'b1;
        wye_r    <= {1'b0, cfg_y1} + 1'b1;
      end else if (take) begin
        fb_addr <= e_cur;
        fb_data <= in_data;
        rem     <= e_rem - 1'b1;
        pitch_r <= e_pitch;
        rb_r    <= e_rb;
        wx0_r   <= e_x0;
        wy0_r   <= e_y0;
        wxe_r   <= e_xe;
        wye_r   <= e_ye;
        if (e_col == RB_W'(1)) begin
          cur      <= e_row + e_pitch;
          row_base <= e_row + e_pitch;
          col_left <= e_rb;
        end else begin
          cur      <= e_cur + 1'b1;
          row_base <= e_row;
          col_left <= e_col - 1'b1;
        end
      end
    end
  end

  wps_dirty_rect #(.COORD_W(COORD_W)) u_dirty (
    .clk(clk), .rst_n(rst_n), .commit(last), .clear(dirty_rd),
    .wx0(e_x0), .wy0(e_y0), .wxe(e_xe), .wye(e_ye),
    .rx0(dirty_x0), .ry0(dirty_y0), .rx1(dirty_x1), .ry1(dirty_y1)
  );
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
  parameter int COORD_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             fb_we,
  input logic             done,
  input logic             err,
  input logic             dirty_rd,
  input logic [COORD_W:0] dirty_x0,
  input logic [COORD_W:0] dirty_y0,
  input logic [COORD_W:0] dirty_x1,
  input logic [COORD_W:0] dirty_y1
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !fb_we); // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !fb_we); // R3
  AST_DIRTY_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dirty_x0 < dirty_x1) && (dirty_y0 < dirty_y1)); // R9
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_rd |=> done || ((dirty_x1 == '0) && (dirty_y1 == '0))); // R10
endmodule

bind win_write_seq wps_checker #(.COORD_W(COORD_W)) u_wps_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .fb_we(fb_we), .done(done), .err(err), .dirty_rd(dirty_rd),
  .dirty_x0(dirty_x0), .dirty_y0(dirty_y0),
  .dirty_x1(dirty_x1), .dirty_y1(dirty_y1)
);

// File: tb/win_write_seq_tb_top.sv
module win_write_seq_tb_top;
  localparam int PW = 800;
  localparam int CW = 10;
  localparam int AW = $clog2(PW * (1 << CW) * 4);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, setup_req, in_valid, in_ready, fb_we, done, err, dirty_rd;
  logic [2:0] cfg_src;
  logic [3:0] cfg_fmt;
  logic [CW-1:0] cfg_x0, cfg_y0, cfg_x1, cfg_y1;
  logic [7:0] in_data, fb_data;
  logic [AW-1:0] fb_addr;
  logic [CW:0] dirty_x0, dirty_y0, dirty_x1, dirty_y1;

  win_write_seq #(.PANEL_W(PW), .COORD_W(CW)) dut_i (.*);

  int checks = 0, fails = 0;
  int ex0 = 2047, ey0 = 2047, ex1 = 0, ey1 = 0;
  bit finished = 0;

  // Vector fields: src(3) fmt(4) x0 y0 x1 y1 (10 each) ok(1)
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {3'd0, 4'd1, 10'd10,  10'd5,   10'd12,  10'd6,   1'b1},
    {3'd3, 4'd2, 10'd0,   10'd0,   10'd1,   10'd1,   1'b1},
    {3'd1, 4'd5, 10'd799, 10'd0,   10'd799, 10'd1,   1'b1},
    {3'd0, 4'd0, 10'd1,   10'd1,   10'd2,   10'd2,   1'b0},
    {3'd0, 4'd1, 10'd5,   10'd1,   10'd4,   10'd2,   1'b0},
    {3'd0, 4'd6, 10'd1,   10'd9,   10'd2,   10'd8,   1'b0},
    {3'd4, 4'd1, 10'd1,   10'd1,   10'd2,   10'd2,   1'b0},
    {3'd2, 4'd3, 10'd100, 10'd200, 10'd100, 10'd200, 1'b1}
  };

  function automatic int bpp_of(input int f);
    case (f)
      1: return 2;
      2, 3: return 3;
      5, 6: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int s, input int f, input int a, input int b, input int c, input int d);
    cfg_src = 3'(s); cfg_fmt = 4'(f);
    cfg_x0 = CW'(a); cfg_y0 = CW'(b); cfg_x1 = CW'(c); cfg_y1 = CW'(d);
  endtask

  task automatic pulse_setup(input bit ok);
    setup_req = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R8 ready low in setup", in_ready, 0);
    @(posedge clk); @(negedge clk);
    setup_req = 1'b0;
    chk(err == !ok, "R3 setup err", err, !ok);
    chk(fb_we == 1'b0, "R3 no write on setup", fb_we, 0);
  endtask

  // Streams n bytes of the configured window starting at byte k0.
  task automatic stream(input int k0, input int n, input bit rd_last);
    int bpp = bpp_of(int'(cfg_fmt));
    int w = int'(cfg_x1) - int'(cfg_x0) + 1;
    int h = int'(cfg_y1) - int'(cfg_y0) + 1;
    int len = bpp * w * h;
    for (int k = k0; k < k0 + n; k++) begin
      int r = k / (bpp * w);
      int c = k % (bpp * w);
      longint ea = longint'((int'(cfg_y0) + r) * PW + int'(cfg_x0)) * bpp + c;
      bit lst = (k == len - 1);
      in_valid = 1'b1; in_data = 8'(k * 7 + 3);
      dirty_rd = rd_last && lst;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; dirty_rd = 1'b0;
      chk(fb_we == 1'b1, "R7 write strobe", fb_we, 1);
      chk(fb_addr == AW'(ea), "R6 address", fb_addr, ea);
      chk(fb_data == 8'(k * 7 + 3), "R7 data", fb_data, k * 7 + 3);
      chk(done == lst, "R4 done on last byte", done, lst);
      if (lst) begin
        if (rd_last) begin
          ex0 = cfg_x0; ey0 = cfg_y0; ex1 = cfg_x1 + 1; ey1 = cfg_y1 + 1;
        end else begin
          if (cfg_x0 < ex0) ex0 = cfg_x0;
          if (cfg_y0 < ey0) ey0 = cfg_y0;
          if (cfg_x1 + 1 > ex1) ex1 = cfg_x1 + 1;
          if (cfg_y1 + 1 > ey1) ey1 = cfg_y1 + 1;
        end
        chk(dirty_x0 == (CW+1)'(ex0), "R9 dirty x0", dirty_x0, ex0);
        chk(dirty_y0 == (CW+1)'(ey0), "R9 dirty y0", dirty_y0, ey0);
        chk(dirty_x1 == (CW+1)'(ex1), "R9 dirty x1", dirty_x1, ex1);
        chk(dirty_y1 == (CW+1)'(ey1), "R9 dirty y1", dirty_y1, ey1);
      end
    end
    @(negedge clk);
    chk(done == 1'b0 && fb_we == 1'b0, "R4 done single pulse", done, 0);
  endtask

  task automatic read_clear();
    dirty_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    dirty_rd = 1'b0;
    ex0 = 2047; ey0 = 2047; ex1 = 0; ey1 = 0;
    chk(dirty_x0 == 11'd2047 && dirty_y0 == 11'd2047, "R10 cleared min", dirty_x0, 2047);
    chk(dirty_x1 == 11'd0 && dirty_y1 == 11'd0, "R10 cleared max", dirty_x1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; setup_req = 1'b0; in_valid = 1'b0; in_data = '0; dirty_rd = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fb_we == 0 && done == 0 && err == 0, "R1 reset strobes", {fb_we, done, err}, 0);
    chk(dirty_x0 == 11'd2047 && dirty_y0 == 11'd2047, "R1 reset dirty min", dirty_x0, 2047);
    chk(dirty_x1 == 11'd0 && dirty_y1 == 11'd0, "R1 reset dirty max", dirty_x1, 0);

    // Vector table: R2 format sizes, R3 rejection, R4 length.
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v = VEC[i];
      set_cfg(int'(v[47:45]), int'(v[44:41]), int'(v[40:31]), int'(v[30:21]),
              int'(v[20:11]), int'(v[10:1]));
      pulse_setup(v[0]);
      if (v[0]) begin
        int n = bpp_of(int'(v[44:41])) * (int'(v[20:11]) - int'(v[40:31]) + 1) *
                (int'(v[10:1]) - int'(v[30:21]) + 1);
        stream(0, n, 1'b0); // R2 byte count via format code
      end
    end
    read_clear();

    // R5 implicit setup on first byte, then R10 read with coincident commit
    set_cfg(0, 1, 2, 2, 2, 2);
    stream(0, 2, 1'b0);
    set_cfg(1, 6, 3, 4, 3, 4);
    stream(0, 4, 1'b1);
    chk(dirty_x0 == 11'd3 && dirty_x1 == 11'd4, "R10 rd with commit", dirty_x1, 4);

    // R5 failed implicit setup drops the byte
    set_cfg(0, 4'd7, 1, 1, 1, 1);
    in_valid = 1'b1; in_data = 8'hAA;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(fb_we == 1'b0, "R5 dropped byte", fb_we, 0);
    chk(err == 1'b1, "R5 implicit err", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R3 err one cycle", err, 0);

    // R8 restart mid-window
    set_cfg(0, 2, 50, 60, 52, 60);
    pulse_setup(1'b1);
    stream(0, 1, 1'b0);
    set_cfg(0, 1, 7, 8, 8, 9);
    pulse_setup(1'b1);
    stream(0, 8, 1'b0); // R8 new window from byte 0

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule